// File: doc/BRIEF.md
# Reorder Buffer with Register Alias Table

This block renames destination registers and retires instructions in program order. Each instruction that enters takes the next free slot of a circular buffer. The slot's index serves as the rename tag. The alias table records, for every architectural register, whether its newest value sits in the register file or is still owned by a buffer slot. Operand lookups return either a usable value or the tag of the producer. Because readers wait on tags rather than register names, write-after-read and write-after-write hazards disappear.

Up to two instructions enter per cycle, in slot 0 then slot 1 order. Execution units report completion with a tag, a result and a fault flag. A completed slot keeps its result until it reaches the oldest position. Up to two results leave per cycle from the oldest end and are written into the register file. A faulting slot, which may also be a mispredicted branch, raises a flush when it is oldest. The flush discards the faulting slot and everything younger, and returns every register to the register file.

Top module: `rob_rename`

## Requirements
- R1: After reset the buffer is empty, `stall` is low, no retire or flush output is active, and every register looks up as ready with value 0.
- R2: Entering instructions receive consecutive slot numbers starting at the tail, with slot 0 older than slot 1. `d1_tag` equals the tail when `d0_valid` is low and the slot after the tail otherwise. Slot numbers wrap from DEPTH-1 to 0.
- R3: A lookup on `src_reg[i]` returns `src_rdy[i]=1` with the register-file value when the register is not owned. When the owning slot has not completed, it returns `src_rdy[i]=0` with the owner's slot number zero-extended in `src_val[i]`. Indices 0 and 1 belong to slot 0, and indices 2 and 3 belong to slot 1.
- R4: A slot-1 source that names the destination of a writing slot-0 instruction in the same cycle returns not ready with `d0_tag`.
- R5: When fewer slots are free than instructions offered, or during a flush, `stall` is high and nothing is allocated. The occupancy never exceeds DEPTH.
- R6: Once its owner has completed, an owned register looks up as ready with the completed result, even if the owner has not yet retired.
- R7: Retirement proceeds from the oldest slot only, and only over completed slots, at most two per cycle. The register file holds each retired result from the next cycle on.
- R8: Retirement returns a register to the register file only when the alias entry still names the retiring slot. A younger writer keeps its mapping.
- R9: A faulting slot at the head drives `flush` and `flush_pc` and writes no result. In the next cycle the buffer is empty, all registers look up from the register file, and the next allocation starts at the slot after the faulting one.
- R10: An instruction with `dN_we` low takes a slot but leaves the alias table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d0_valid | input | 1 | Older entering instruction present |
| d0_we | input | 1 | Older instruction writes a register |
| d0_dst | input | RW | Older instruction destination |
| d0_pc | input | PCW | Older instruction address |
| d1_valid | input | 1 | Younger entering instruction present |
| d1_we | input | 1 | Younger instruction writes a register |
| d1_dst | input | RW | Younger instruction destination |
| d1_pc | input | PCW | Younger instruction address |
| src_reg | input | 4 x RW | Source registers to look up |
| src_rdy | output | 4 | Lookup returned a value |
| src_val | output | 4 x DW | Value, or producer slot when not ready |
| stall | output | 1 | Entering instructions refused this cycle |
| d0_tag | output | TW | Slot for the older instruction |
| d1_tag | output | TW | Slot for the younger instruction |
| cm_valid | input | 1 | Completion report present |
| cm_tag | input | TW | Completing slot |
| cm_data | input | DW | Completed result |
| cm_exc | input | 1 | Completion is a fault or misprediction |
| rt0_valid | output | 1 | Oldest slot retires |
| rt0_wr | output | 1 | Oldest retiring slot writes a register |
| rt0_dst | output | RW | Its destination |
| rt0_data | output | DW | Its result |
| rt1_valid | output | 1 | Second slot retires |
| rt1_wr | output | 1 | Second retiring slot writes a register |
| rt1_dst | output | RW | Its destination |
| rt1_data | output | DW | Its result |
| flush | output | 1 | Fault at head, younger state discarded |
| flush_pc | output | PCW | Address of the faulting instruction |

## Verification
The bench fills the buffer past the wrap point until it is full. A design that miscounts free slots would accept an instruction into an occupied slot, or would stall one that fits. It retires an older writer while a younger writer of the same register is still pending. A design that clears the alias entry without comparing tags would then hand out the stale register-file value. It checks the same-cycle pair where slot 1 reads slot 0's destination, which a design without the bypass answers from the old mapping. It also checks that a completed slot waiting behind an older incomplete slot never retires early. Finally, it raises a fault in the middle of a full buffer and checks the register values and the next allocated slot afterwards, which catches a flush that leaves stale owners or a wrong tail.

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int DEPTH = 8,
  parameter int NREG  = 8,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  localparam int TW   = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 d0_valid,
  input  logic                 d0_we,
  input  logic [RW-1:0]        d0_dst,
  input  logic [PCW-1:0]       d0_pc,
  input  logic                 d1_valid,
  input  logic                 d1_we,
  input  logic [RW-1:0]        d1_dst,
  input  logic [PCW-1:0]       d1_pc,
  input  logic [3:0][RW-1:0]   src_reg,
  output logic [3:0]           src_rdy,
  output logic [3:0][DW-1:0]   src_val,
  output logic                 stall,
  output logic [TW-1:0]        d0_tag,
  output logic [TW-1:0]        d1_tag,
  input  logic                 cm_valid,
  input  logic [TW-1:0]        cm_tag,
  input  logic [DW-1:0]        cm_data,
  input  logic                 cm_exc,
  output logic                 rt0_valid,
  output logic                 rt0_wr,
  output logic [RW-1:0]        rt0_dst,
  output logic [DW-1:0]        rt0_data,
  output logic                 rt1_valid,
  output logic                 rt1_wr,
  output logic [RW-1:0]        rt1_dst,
  output logic [DW-1:0]        rt1_data,
  output logic                 flush,
  output logic [PCW-1:0]       flush_pc
);
  localparam int CW = TW + 1;

  logic [TW-1:0]  head, tail, head1;
  logic [CW-1:0]  cnt, need, free;
  logic [DEPTH-1:0] done, exc, we;
  logic [RW-1:0]  dst [DEPTH];
  logic [DW-1:0]  res [DEPTH];
  logic [PCW-1:0] pc  [DEPTH];
  logic [NREG-1:0] in_rf;
  logic [TW-1:0]  map [NREG];
  logic [DW-1:0]  rf  [NREG];
  logic           go0, go1;

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] p);
    return (p == TW'(DEPTH - 1)) ? '0 : p + TW'(1);
  endfunction

  assign head1     = nxt(head);
  assign flush     = (cnt != '0) && done[head] && exc[head];
  assign flush_pc  = pc[head];
  assign rt0_valid = (cnt != '0) && done[head] && !exc[head];
  assign rt1_valid = rt0_valid && (cnt >= CW'(2)) && done[head1] && !exc[head1];
  assign rt0_wr    = we[head];
  assign rt0_dst   = dst[head];
  assign rt0_data  = res[head];
  assign rt1_wr    = we[head1];
  assign rt1_dst   = dst[head1];
  assign rt1_data  = res[head1];

  assign need   = CW'(d0_valid) + CW'(d1_valid);
  assign free   = CW'(DEPTH) - cnt;
  assign stall  = flush || (need > free);
  assign go0    = d0_valid && !stall;
  assign go1    = d1_valid && !stall;
  assign d0_tag = tail;
  assign d1_tag = d0_valid ? nxt(tail) : tail;

  for (genvar i = 0; i < 4; i++) begin : g_look
    logic          rdy;
    logic [DW-1:0] val;
    logic [RW-1:0] r;
    assign r = src_reg[i];
    always_comb begin
      if (i >= 2 && d0_valid && d0_we && d0_dst == r) begin
        rdy = 1'b0;
        val = {{(DW-TW){1'b0}}, d0_tag};
      end else if (in_rf[r]) begin
        rdy = 1'b1;
        val = rf[r];
      end else if (done[map[r]]) begin
        rdy = 1'b1;
        val = res[map[r]];
      end else begin
        rdy = 1'b0;
        val = {{(DW-TW){1'b0}}, map[r]};
      end
    end
    assign src_rdy[i] = rdy;
    assign src_val[i] = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      cnt   <= '0;
      done  <= '0;
      exc   <= '0;
      we    <= '0;
      in_rf <= '1;
      for (int k = 0; k < NREG; k++) begin
        map[k] <= '0;
        rf[k]  <= '0;
      end
    end else if (flush) begin
      head  <= head1;
      tail  <= head1;
      cnt   <= '0;
      done  <= '0;
      in_rf <= '1;
    end else begin
      if (cm_valid) begin
        done[cm_tag] <= 1'b1;
        exc[cm_tag]  <= cm_exc;
        res[cm_tag]  <= cm_data;
      end
      if (rt0_valid && we[head]) begin
        rf[dst[head]] <= res[head];
        if (map[dst[head]] == head) in_rf[dst[head]] <= 1'b1;
      end
      if (rt1_valid && we[head1]) begin
        rf[dst[head1]] <= res[head1];
        if (map[dst[head1]] == head1) in_rf[dst[head1]] <= 1'b1;
      end
      if (go0) begin
        done[d0_tag] <= 1'b0;
        exc[d0_tag]  <= 1'b0;
        we[d0_tag]   <= d0_we;
        dst[d0_tag]  <= d0_dst;
        pc[d0_tag]   <= d0_pc;
        if (d0_we) begin
          in_rf[d0_dst] <= 1'b0;
          map[d0_dst]   <= d0_tag;
        end
      end
      if (go1) begin
        done[d1_tag] <= 1'b0;
        exc[d1_tag]  <= 1'b0;
        we[d1_tag]   <= d1_we;
        dst[d1_tag]  <= d1_dst;
        pc[d1_tag]   <= d1_pc;
        if (d1_we) begin
          in_rf[d1_dst] <= 1'b0;
          map[d1_dst]   <= d1_tag;
        end
      end
      head <= rt1_valid ? nxt(head1) : (rt0_valid ? head1 : head);
      tail <= go1 ? nxt(d1_tag) : (go0 ? nxt(tail) : tail);
      cnt  <= cnt + CW'(go0) + CW'(go1) - CW'(rt0_valid) - CW'(rt1_valid);
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> cnt <= $past(cnt));

  // R1
  empty_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (head == tail));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0) && (&in_rf));

  // R7
  rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt0_valid && rt0_wr && !(rt1_valid && rt1_wr && rt1_dst == rt0_dst))
    |=> rf[$past(rt0_dst)] == $past(rt0_data));
endmodule

// File: tb/test_rob_rename.sv
module test_rob_rename;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d0_valid, d0_we, d1_valid, d1_we;
  logic [2:0] d0_dst, d1_dst;
  logic [31:0] d0_pc, d1_pc;
  logic [3:0][2:0] src_reg;
  logic [3:0] src_rdy;
  logic [3:0][31:0] src_val;
  logic stall;
  logic [2:0] d0_tag, d1_tag;
  logic cm_valid, cm_exc;
  logic [2:0] cm_tag;
  logic [31:0] cm_data;
  logic rt0_valid, rt0_wr, rt1_valid, rt1_wr, flush;
  logic [2:0] rt0_dst, rt1_dst;
  logic [31:0] rt0_data, rt1_data, flush_pc;
  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  rob_rename i_rob_rename (
    .clk(clk), .rst_n(rst_n),
    .d0_valid(d0_valid), .d0_we(d0_we), .d0_dst(d0_dst), .d0_pc(d0_pc),
    .d1_valid(d1_valid), .d1_we(d1_we), .d1_dst(d1_dst), .d1_pc(d1_pc),
    .src_reg(src_reg), .src_rdy(src_rdy), .src_val(src_val),
    .stall(stall), .d0_tag(d0_tag), .d1_tag(d1_tag),
    .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_data(cm_data), .cm_exc(cm_exc),
    .rt0_valid(rt0_valid), .rt0_wr(rt0_wr), .rt0_dst(rt0_dst), .rt0_data(rt0_data),
    .rt1_valid(rt1_valid), .rt1_wr(rt1_wr), .rt1_dst(rt1_dst), .rt1_data(rt1_data),
    .flush(flush), .flush_pc(flush_pc)
  );

  // {d0v, d0dst, d1v, d1dst, stall, t0, t1}
  localparam logic [14:0] VEC [7] = '{
    {1'b1, 3'd1, 1'b1, 3'd2, 1'b0, 3'd0, 3'd1},
    {1'b1, 3'd3, 1'b1, 3'd1, 1'b0, 3'd2, 3'd3},
    {1'b1, 3'd4, 1'b0, 3'd0, 1'b0, 3'd4, 3'd5},
    {1'b1, 3'd5, 1'b1, 3'd6, 1'b0, 3'd5, 3'd6},
    {1'b1, 3'd7, 1'b1, 3'd2, 1'b1, 3'd7, 3'd0},
    {1'b1, 3'd7, 1'b0, 3'd0, 1'b0, 3'd7, 3'd0},
    {1'b1, 3'd0, 1'b0, 3'd0, 1'b1, 3'd0, 3'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    d0_valid = 0; d0_we = 0; d0_dst = 0; d0_pc = 0;
    d1_valid = 0; d1_we = 0; d1_dst = 0; d1_pc = 0;
    cm_valid = 0; cm_tag = 0; cm_data = 0; cm_exc = 0;
  endtask

  task automatic nx();
    @(negedge clk);
    idle();
  endtask

  task automatic look(input int i, input logic [2:0] r, input string req,
                      input logic rdy, input logic [31:0] val);
    src_reg[i] = r;
    #1;
    chk(req, {31'b0, src_rdy[i]}, {31'b0, rdy});
    chk(req, src_val[i], val);
  endtask

  task automatic complete(input logic [2:0] t, input logic [31:0] d, input logic e);
    cm_valid = 1; cm_tag = t; cm_data = d; cm_exc = e;
    nx();
    #1;
  endtask

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    idle();
    src_reg = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk("R1 stall", {31'b0, stall}, 0);
    chk("R1 retire", {30'b0, rt0_valid, flush}, 0);
    for (int i = 0; i < 4; i++) look(i, 3'(i + 4), "R1 lookup", 1'b1, 0);

    // R2 R5: table walk
    for (int v = 0; v < 7; v++) begin
      d0_valid = VEC[v][14]; d0_dst = VEC[v][13:11]; d0_we = 1;
      d1_valid = VEC[v][10]; d1_dst = VEC[v][9:7];   d1_we = 1;
      d0_pc = 32'h100 + 32'(v * 8);
      d1_pc = 32'h104 + 32'(v * 8);
      #1;
      chk("R5 stall", {31'b0, stall}, {31'b0, VEC[v][6]});
      chk("R2 d0_tag", {29'b0, d0_tag}, {29'b0, VEC[v][5:3]});
      chk("R2 d1_tag", {29'b0, d1_tag}, {29'b0, VEC[v][2:0]});
      nx();
    end

    // R3: r0 in file, r1 -> 3, r2 -> 1, r7 -> 7
    look(0, 3'd0, "R3 free reg", 1'b1, 0);
    look(1, 3'd1, "R3 owned r1", 1'b0, 3);
    look(2, 3'd2, "R3 owned r2", 1'b0, 1);
    look(3, 3'd7, "R3 owned r7", 1'b0, 7);

    // R7 R8: retire older writer of r1 while younger pending
    complete(3'd0, 32'h10, 1'b0);
    chk("R7 rt0_valid", {31'b0, rt0_valid}, 1);
    chk("R7 rt0_dst", {29'b0, rt0_dst}, 1);
    chk("R7 rt0_data", rt0_data, 32'h10);
    chk("R7 rt1_valid", {31'b0, rt1_valid}, 0);
    nx();
    look(1, 3'd1, "R8 younger keeps map", 1'b0, 3);

    // R6 R7: completed non-head waits
    complete(3'd3, 32'h33, 1'b0);
    chk("R7 no early retire", {31'b0, rt0_valid}, 0);
    look(1, 3'd1, "R6 completed owner", 1'b1, 32'h33);
    complete(3'd2, 32'h32, 1'b0);
    chk("R7 head incomplete", {31'b0, rt0_valid}, 0);
    complete(3'd1, 32'h21, 1'b0);
    chk("R7 two retire rt0", {rt0_valid, rt1_valid, 27'b0, rt0_dst}, 32'hC000_0002);
    chk("R7 rt0_data", rt0_data, 32'h21);
    chk("R7 rt1 dst", {29'b0, rt1_dst}, 3);
    chk("R7 rt1_data", rt1_data, 32'h32);
    nx();
    #1;
    chk("R7 third retire", {rt0_valid, rt1_valid, 27'b0, rt0_dst}, 32'h8000_0001);
    nx();
    look(0, 3'd1, "R7 r1 file", 1'b1, 32'h33);
    look(1, 3'd2, "R8 r2 restored", 1'b1, 32'h21);
    look(2, 3'd3, "R8 r3 restored", 1'b1, 32'h32);

    // R4 R2: same-cycle bypass and wrap
    d0_valid = 1; d0_we = 1; d0_dst = 3; d0_pc = 32'h200;
    d1_valid = 1; d1_we = 1; d1_dst = 5; d1_pc = 32'h204;
    src_reg[0] = 3'd3; src_reg[2] = 3'd3;
    #1;
    chk("R2 wrap tags", {26'b0, d0_tag, d1_tag}, {26'b0, 3'd0, 3'd1});
    chk("R4 slot0 old map", {31'b0, src_rdy[0]}, 1);
    chk("R4 slot0 value", src_val[0], 32'h32);
    chk("R4 bypass rdy", {31'b0, src_rdy[2]}, 0);
    chk("R4 bypass tag", src_val[2], 0);
    nx();

    // R10: no-destination instruction
    d0_valid = 1; d0_we = 0; d0_dst = 4; d0_pc = 32'h208;
    #1;
    chk("R10 tag", {29'b0, d0_tag}, 2);
    nx();
    look(0, 3'd4, "R10 map kept", 1'b0, 4);

    // R9: fault at head (slot 4, pc 0x110)
    complete(3'd4, 32'h99, 1'b1);
    chk("R9 flush", {31'b0, flush}, 1);
    chk("R9 flush_pc", flush_pc, 32'h110);
    chk("R9 stall", {31'b0, stall}, 1);
    chk("R9 no retire", {31'b0, rt0_valid}, 0);
    nx();
    look(0, 3'd4, "R9 no write", 1'b1, 0);
    look(1, 3'd3, "R9 r3 restored", 1'b1, 32'h32);
    look(2, 3'd5, "R9 r5 restored", 1'b1, 0);
    d0_valid = 1; d0_we = 1; d0_dst = 6;
    #1;
    chk("R9 stall clear", {31'b0, stall}, 0);
    chk("R9 next tag", {29'b0, d0_tag}, 5);
    nx();

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule